// File: doc/BRIEF.md
# DMA Completion Interrupt Aggregator

This block gathers the level-sensitive completion flags of a bank of DMA channels and turns them into interrupt requests for a processor. Each channel flag is registered into a global status word that software can read to see which channels are finished. The registered flags are then folded onto controller lines. The low channels each get a line of their own. The remaining high channels share one line through an OR.

The lines land in a controller section that has a mask, a pending word and a summary word. Software unmasks lines by writing ones to a set-enable address and masks them by writing ones to a clear-enable address. A pending bit is visible only while its line is unmasked. The summary word raises a single aggregate bit whenever any pending bit is up, and the processor request follows the summary. Pending bits are not latched: they follow the channel flags. Software clears an interrupt at the channel, and that is outside this block.

All registers sit behind one simple register-slave bus with single-cycle write strobes and reads that return one cycle after the strobe.

Top module: `dmairq_top`

## Requirements
- R1: The global status register at offset 0xFE0 has bit n set to channel n's flag (n = 0 to 14) as sampled on the previous clock edge. Bits 15 to 31 read as zero.
- R2: Channels 0 to 10 each drive line k = n. When line k is unmasked, bit 16+k of the pending register at offset 0x04 equals that line.
- R3: Channels 11 to 14 are ORed onto line 11, which shows as pending bit 27.
- R4: Writing to offset 0x10 sets each mask bit whose write-data bit is 1, for bits 16 to 27 only. Zero bits leave the mask unchanged. A read of 0x10 returns the mask, with all other bits zero.
- R5: Writing to offset 0x1C clears each mask bit whose write-data bit is 1. Zero bits leave it unchanged.
- R6: A line whose mask bit is clear never shows in the pending register, even while its channel flag is set.
- R7: The summary register at offset 0x00 reads 0x100 (bit 8) while any pending bit is set, and 0 otherwise.
- R8: `irq_o` is high exactly when the summary register was nonzero on the previous clock edge. It therefore rises two edges after a flag of an unmasked line is applied.
- R9: After synchronous reset, the status, pending, summary and mask registers all read zero and `irq_o` is low.
- R10: Writes to 0x00, 0x04 and 0xFE0 have no effect. Reads of any unmapped offset return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_flag_i | input | 15 | Per-channel completion flags, level |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | 12 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid with bus_rvalid_o |
| bus_rvalid_o | output | 1 | High one cycle after a read strobe |
| irq_o | output | 1 | Processor interrupt request |

## Verification
A flag applied before an edge reaches the status register at that edge, and pending and summary follow it without further delay. A read strobe returns data one edge later, and `irq_o` lags the pending state by one more edge. The bench drives on falling edges and waits one full cycle after every flag or mask change before it issues a read. The monitor compares read data on the falling edge after the strobe. `irq_o` is sampled two falling edges after a flag change, and in one case also after a single edge, to confirm it has not yet risen.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;
  localparam int ADDR_W = 12;
  localparam logic [ADDR_W-1:0] OFS_SUMMARY = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_PENDING = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_EN_SET  = 12'h010;
  localparam logic [ADDR_W-1:0] OFS_EN_CLR  = 12'h01C;
  localparam logic [ADDR_W-1:0] OFS_GSTAT   = 12'hFE0;
  localparam int LINE_BASE = 16;
  localparam int AGGR_BIT  = 8;
endpackage

// File: rtl/dmairq_status.sv
module dmairq_status #(
  parameter int NUM_CH = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] flags_i,
  output logic [NUM_CH-1:0] status_o
);
  always_ff @(posedge clk) begin
    if (rst) status_o <= '0;
    else     status_o <= flags_i;
  end

  AST_STATUS_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (status_o == $past(flags_i))); // R1
endmodule

// File: rtl/dmairq_route.sv
module dmairq_route #(
  parameter int NUM_CH    = 15,
  parameter int NUM_DED   = 11,
  parameter int NUM_LINES = NUM_DED + 1
) (
  input  logic [NUM_CH-1:0]    status_i,
  output logic [NUM_LINES-1:0] lines_o
);
  for (genvar k = 0; k < NUM_DED; k++) begin : g_ded
    assign lines_o[k] = status_i[k];
  end
  assign lines_o[NUM_DED] = |status_i[NUM_CH-1:NUM_DED];
endmodule

// File: rtl/dmairq_ctrl.sv
module dmairq_ctrl
  import dmairq_pkg::*;
#(
  parameter int NUM_LINES = 12,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] lines_i,
  input  logic                 en_set_i,
  input  logic                 en_clr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    en_o,
  output logic [DATA_W-1:0]    pend_o,
  output logic [DATA_W-1:0]    summary_o,
  output logic                 irq_o
);
  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};
  localparam logic [DATA_W-1:0] FIELD_MASK = ((ONE << NUM_LINES) - ONE) << LINE_BASE;

  logic [DATA_W-1:0] wmask;
  logic [DATA_W-1:0] lines_w;

  assign wmask   = wdata_i & FIELD_MASK;
  assign lines_w = {{(DATA_W-NUM_LINES){1'b0}}, lines_i} << LINE_BASE;

  always_ff @(posedge clk) begin
    if (rst)           en_o <= '0;
    else if (en_set_i) en_o <= en_o | wmask;
    else if (en_clr_i) en_o <= en_o & ~wmask;
  end

  assign pend_o    = lines_w & en_o;
  assign summary_o = (pend_o != '0) ? (ONE << AGGR_BIT) : '0;

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= (summary_o != '0);
  end

  AST_ENABLE_SET: assert property (@(posedge clk) disable iff (rst)
    en_set_i |=> ((en_o & $past(wmask)) == $past(wmask))); // R4
  AST_DISABLE_CLR: assert property (@(posedge clk) disable iff (rst)
    en_clr_i |=> ((en_o & $past(wmask)) == '0)); // R5
  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_o == $past(summary_o != '0))); // R8
endmodule

// File: rtl/dmairq_top.sv
module dmairq_top
  import dmairq_pkg::*;
#(
  parameter int NUM_CH  = 15,
  parameter int NUM_DED = 11,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] ch_flag_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              bus_rvalid_o,
  output logic              irq_o
);
  localparam int NUM_LINES = NUM_DED + 1;
  localparam int SHARED_BIT = LINE_BASE + NUM_DED;

  logic [NUM_CH-1:0]    status;
  logic [NUM_LINES-1:0] lines;
  logic [DATA_W-1:0]    en, pend, summary;
  logic                 en_set, en_clr;

  assign en_set = bus_wr_i && (bus_addr_i == OFS_EN_SET);
  assign en_clr = bus_wr_i && (bus_addr_i == OFS_EN_CLR);

  dmairq_status #(.NUM_CH(NUM_CH)) u_status (
    .clk(clk), .rst(rst), .flags_i(ch_flag_i), .status_o(status));

  dmairq_route #(.NUM_CH(NUM_CH), .NUM_DED(NUM_DED), .NUM_LINES(NUM_LINES)) u_route (
    .status_i(status), .lines_o(lines));

  dmairq_ctrl #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst), .lines_i(lines), .en_set_i(en_set), .en_clr_i(en_clr),
    .wdata_i(bus_wdata_i), .en_o(en), .pend_o(pend), .summary_o(summary),
    .irq_o(irq_o));

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rvalid_o <= 1'b0;
      bus_rdata_o  <= '0;
    end else begin
      bus_rvalid_o <= bus_rd_i;
      if (bus_rd_i) begin
        case (bus_addr_i)
          OFS_GSTAT:   bus_rdata_o <= {{(DATA_W-NUM_CH){1'b0}}, status};
          OFS_PENDING: bus_rdata_o <= pend;
          OFS_SUMMARY: bus_rdata_o <= summary;
          OFS_EN_SET:  bus_rdata_o <= en;
          default:     bus_rdata_o <= '0;
        endcase
      end
    end
  end

  AST_SHARED_PEND: assert property (@(posedge clk) disable iff (rst)
    ((|status[NUM_CH-1:NUM_DED]) && en[SHARED_BIT]) |-> pend[SHARED_BIT]); // R3
  AST_SUMMARY_AGGR: assert property (@(posedge clk) disable iff (rst)
    (pend != '0) |-> summary[AGGR_BIT]); // R7
endmodule

// File: tb/dmairq_top_bench.sv
module dmairq_top_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [14:0] ch_flag = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid, irq;

  int n_vec = 0, n_bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [14:0] flags_m = '0;
  logic [31:0] en_m = '0;

  always #10 clk = ~clk;

  dmairq_top u_dmairq_top (
    .clk(clk), .rst(rst), .ch_flag_i(ch_flag), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .bus_rvalid_o(bus_rvalid), .irq_o(irq));

  function automatic logic [31:0] m_pend();
    logic [11:0] ln = {|flags_m[14:11], flags_m[10:0]};
    return ({20'd0, ln} << 16) & en_m;
  endfunction
  function automatic logic [31:0] m_sum();
    return (m_pend() != 0) ? 32'h100 : 32'h0;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(logic [11:0] a, logic [31:0] exp, string tag);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    if (a == 12'h010) en_m = en_m | (d & 32'h0FFF0000);
    if (a == 12'h01C) en_m = en_m & ~(d & 32'h0FFF0000);
  endtask

  task automatic flags(logic [14:0] f);
    ch_flag = f; flags_m = f;
    @(negedge clk);
  endtask

  task automatic check_all(string tag);
    rd(12'hFE0, {17'd0, flags_m}, {tag, " status"});
    rd(12'h004, m_pend(), {tag, " pending"});
    rd(12'h000, m_sum(), {tag, " summary"});
    chk({tag, " irq"}, {31'd0, irq}, {31'd0, m_sum() != 0});
  endtask

  // monitor: scoreboard pops on every read response
  always @(negedge clk) begin
    if (bus_rvalid) begin
      if (exp_q.size() == 0) chk("R10 unexpected read response", bus_rdata, 32'hX);
      else chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL R8 watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check_all("R9 reset");
    rd(12'h010, 32'h0, "R9 reset mask");
    // R1 R6: flag without mask
    flags(15'h0001);
    @(negedge clk);
    check_all("R1 R6 unmasked ch0");
    // R4 R2 R7 R8
    wr(12'h010, 32'h0001_0000);
    rd(12'h010, 32'h0001_0000, "R4 mask read");
    @(negedge clk);
    check_all("R2 R7 R8 ch0 enabled");
    wr(12'h010, 32'hFFFF_FFFF);
    rd(12'h010, 32'h0FFF_0000, "R4 mask field only");
    wr(12'h010, 32'h0);
    rd(12'h010, 32'h0FFF_0000, "R4 zero write no effect");
    // R2 ch10
    flags(15'h0400);
    @(negedge clk);
    check_all("R2 ch10");
    // R3 shared line
    flags(15'h0800); @(negedge clk); check_all("R3 ch11");
    flags(15'h4000); @(negedge clk); check_all("R3 ch14");
    flags(15'h4800); @(negedge clk); check_all("R3 ch11 ch14");
    // R5 R6 mask shared line
    wr(12'h01C, 32'h0800_0000);
    rd(12'h010, 32'h07FF_0000, "R5 clear bit27");
    @(negedge clk);
    check_all("R5 R6 shared masked");
    wr(12'h01C, 32'h0);
    rd(12'h010, 32'h07FF_0000, "R5 zero clear no effect");
    // R10 read-only writes and unmapped reads
    flags(15'h0003);
    wr(12'hFE0, 32'hFFFF_FFFF);
    wr(12'h004, 32'hFFFF_FFFF);
    wr(12'h000, 32'hFFFF_FFFF);
    rd(12'h010, 32'h07FF_0000, "R10 mask after ro writes");
    check_all("R10 after ro writes");
    rd(12'h008, 32'h0, "R10 unmapped");
    rd(12'h1C0, 32'h0, "R10 unmapped high");
    // R8 latency: flags clear then set again
    flags(15'h0000);
    @(negedge clk);
    chk("R8 irq low", {31'd0, irq}, 32'd0);
    flags(15'h0020);
    chk("R8 irq not yet", {31'd0, irq}, 32'd0);
    @(negedge clk);
    chk("R8 irq after two edges", {31'd0, irq}, 32'd1);
    // R9 reset mid-run
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    en_m = '0; flags(15'h0000);
    check_all("R9 second reset");
    rd(12'h010, 32'h0, "R9 mask after reset");
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) chk("R10 missing read response", 32'(exp_q.size()), 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule